// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

This block is an 8-bit up-counting timer fed either by the core's instruction-cycle enable or by edges on an external count pin. A single 8-bit prescaler serves two clients. It can slow the timer's count source, or it can divide a raw tick from the watchdog path, and an assignment bit decides which client owns it. The client that does not own the prescaler runs at 1:1. The divide ratio comes from a 3-bit rate code, and its meaning depends on the owner. The timer sees ratios from 1:2 to 1:256. The watchdog sees ratios from 1:1 to 1:128.

The surrounding core supplies a configuration byte and a timer write port. It also supplies a watchdog-clear strobe and a raw watchdog tick, which is already in the `clk` domain. The block returns three outputs: the timer value, a one-cycle overflow pulse for the interrupt logic, and a divided watchdog tick for the watchdog counter. The block does not contain the watchdog oscillator or any reset generation.

Top module: `tps_timer_top`

## Requirements
- R1: The timer is an 8-bit up counter that wraps from FFh to 00h. A wrap raises `tmr_ovf_o` for exactly one cycle, and that cycle is the first cycle in which `tmr_value_o` reads 00h.
- R2: Bit 5 of `opt_i` selects the count source. When it is 0, every cycle with `cyc_en_i` high is a source tick. When it is 1, qualified edges of `ext_pin_i` are source ticks. With no source tick and no write, the timer holds its value.
- R3: `ext_pin_i` passes through a two-flop synchronizer before edge detection. Bit 4 of `opt_i` chooses the edge: 1 counts high-to-low and 0 counts low-to-high. Each qualifying edge gives exactly one source tick, three clock edges after the pin changes.
- R4: Bit 3 of `opt_i` assigns the prescaler. When it is 1, the prescaler belongs to the watchdog and each source tick advances the timer by one on the next clock edge. When it is 0, the prescaler belongs to the timer.
- R5: When the prescaler belongs to the timer, rate code n in bits 2:0 of `opt_i` passes one timer increment per 2^(n+1) source ticks (000 gives 1:2, 111 gives 1:256).
- R6: When the prescaler belongs to the watchdog, rate code n gives one `wdt_tick_o` pulse per 2^n raw ticks (000 gives 1:1, 111 gives 1:128). When it belongs to the timer, every `wdt_raw_i` pulse appears on `wdt_tick_o` one cycle later.
- R7: A write through `tmr_we_i` loads `tmr_wdata_i` on the next edge and takes priority over a same-cycle tick. Counting then resumes from the loaded value. The write also clears the prescaler count while the prescaler belongs to the timer.
- R8: `wdt_clr_i` clears the prescaler count while the prescaler belongs to the watchdog. While the prescaler belongs to the timer, the strobe leaves the prescaler count unchanged.
- R9: After reset the timer reads 00h, the prescaler count is zero, and neither `tmr_ovf_o` nor `wdt_tick_o` is asserted.
- R10: Bits 7:6 of `opt_i` have no effect. An option byte of FFh selects the external source, the falling edge, watchdog ownership and the 1:128 watchdog ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en_i | input | 1 | Instruction-cycle enable, one pulse per instruction cycle |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| opt_i | input | 8 | Option byte: [5] source, [4] edge, [3] assignment, [2:0] rate |
| tmr_we_i | input | 1 | Timer register write strobe |
| tmr_wdata_i | input | 8 | Timer register write data |
| wdt_raw_i | input | 1 | Raw watchdog tick, one-cycle pulses |
| wdt_clr_i | input | 1 | Watchdog-clear strobe |
| tmr_value_o | output | 8 | Current timer value |
| tmr_ovf_o | output | 1 | One-cycle pulse on FFh to 00h wrap |
| wdt_tick_o | output | 1 | Divided (or passed-through) watchdog tick |

## Verification
The bench sweeps every rate code under both owners. A design that counted the shared ratio as 2^n for the timer would advance the timer twice as fast as expected. A design that left the 1:1 watchdog case out would swallow ticks. The bench issues timer writes in the same cycle as a prescaled tick, and a design that gave the tick priority would show the written value plus one. Clear strobes are aimed at the prescaler owner that should ignore them, so a wrong clear rule shifts the phase of every later tick. The external pin is toggled on both edge settings, and a missing history flop or an inverted edge choice would double the counts or shift them by a cycle.

// File: rtl/tps_pkg.sv
package tps_pkg;

   // Fields of the option byte that this block decodes.
   typedef struct packed {
      logic       ext_src;    // 1: external pin edges, 0: cycle enable
      logic       fall_edge;  // 1: count high-to-low
      logic       to_wdt;     // 1: prescaler owned by watchdog
      logic [2:0] rate;       // ratio code
   } opt_fields_t;

   function automatic opt_fields_t decode_opt(input logic [7:0] b);
      opt_fields_t f;
      f.ext_src   = b[5];
      f.fall_edge = b[4];
      f.to_wdt    = b[3];
      f.rate      = b[2:0];
      return f;
   endfunction

   // log2 of the divide ratio: timer side has one extra stage.
   function automatic logic [3:0] div_log2(input logic to_wdt, input logic [2:0] rate);
      return to_wdt ? {1'b0, rate} : ({1'b0, rate} + 4'd1);
   endfunction

endpackage

// File: rtl/tps_edge_sync.sv
module tps_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   localparam int LAST = STAGES;

   initial assert (STAGES >= 2) else $error("tps_edge_sync: STAGES must be at least 2");

   // sh[0..STAGES-1] synchronizer, sh[STAGES] history for the edge detector
   logic [LAST:0] sh_q;

   generate
      for (genvar g = 0; g <= LAST; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh_q[0] <= 1'b0;
               else        sh_q[0] <= pin_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh_q[g] <= 1'b0;
               else        sh_q[g] <= sh_q[g-1];
         end
      end
   endgenerate

   assign rise_o =  sh_q[LAST-1] & ~sh_q[LAST];
   assign fall_o = ~sh_q[LAST-1] &  sh_q[LAST];

   // R3
   single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
   // R3
   single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/tps_prescaler.sv
module tps_prescaler #(
   parameter int PW = 8,
   parameter int RW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pulse_i,
   input  logic          clr_i,
   input  logic [RW:0]   div_i,
   output logic          tick_o
);
   localparam int MAXDIV = 1 << RW;

   initial assert (PW >= MAXDIV) else $error("tps_prescaler: PW too small for rate field");

   logic [PW-1:0] cnt_q;
   logic [PW:0]   full_mask;
   logic [PW-1:0] mask;

   assign full_mask = ({{PW{1'b0}}, 1'b1} << div_i) - {{PW{1'b0}}, 1'b1};
   assign mask      = full_mask[PW-1:0];
   assign tick_o    = pulse_i & ((cnt_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (pulse_i) cnt_q <= cnt_q + 1'b1;

   // R8
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_q == '0);
   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i && !pulse_i |=> $stable(cnt_q));

endmodule

// File: rtl/tps_counter.sv
module tps_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   input  logic         tick_i,
   output logic [W-1:0] value_o,
   output logic         ovf_o
);
   localparam logic [W-1:0] TOP = '1;

   initial assert (W >= 2) else $error("tps_counter: W must be at least 2");

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         value_o <= '0;
         ovf_o   <= 1'b0;
      end else begin
         ovf_o <= !we_i && tick_i && (value_o == TOP);
         if (we_i)        value_o <= wdata_i;
         else if (tick_i) value_o <= value_o + 1'b1;
      end

   // R1
   wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> value_o == '0);
   // R7
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> value_o == $past(wdata_i));
   // R1
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i && tick_i |=> value_o == W'($past(value_o) + 1'b1));

endmodule

// File: rtl/tps_timer_top.sv
module tps_timer_top #(
   parameter int TW    = 8,
   parameter int PW    = 8,
   parameter int RW    = 3,
   parameter int SYNC  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cyc_en_i,
   input  logic          ext_pin_i,
   input  logic [7:0]    opt_i,
   input  logic          tmr_we_i,
   input  logic [TW-1:0] tmr_wdata_i,
   input  logic          wdt_raw_i,
   input  logic          wdt_clr_i,
   output logic [TW-1:0] tmr_value_o,
   output logic          tmr_ovf_o,
   output logic          wdt_tick_o
);
   import tps_pkg::*;

   initial assert (RW == 3) else $error("tps_timer_top: option byte carries a 3-bit rate");

   opt_fields_t opt;
   logic        pin_rise, pin_fall, pin_edge;
   logic        src_tick, pre_in, pre_clr, pre_tick, tmr_tick;
   logic [RW:0] div_sel;

   assign opt = decode_opt(opt_i);

   tps_edge_sync #(.STAGES(SYNC)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (ext_pin_i),
      .rise_o(pin_rise),
      .fall_o(pin_fall)
   );

   assign pin_edge = opt.fall_edge ? pin_fall : pin_rise;
   assign src_tick = opt.ext_src   ? pin_edge : cyc_en_i;

   // Prescaler routing
   assign pre_in  = opt.to_wdt ? wdt_raw_i : src_tick;
   assign pre_clr = opt.to_wdt ? wdt_clr_i : tmr_we_i;
   assign div_sel = div_log2(opt.to_wdt, opt.rate);

   tps_prescaler #(.PW(PW), .RW(RW)) i_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .pulse_i(pre_in),
      .clr_i  (pre_clr),
      .div_i  (div_sel),
      .tick_o (pre_tick)
   );

   assign tmr_tick = opt.to_wdt ? src_tick : pre_tick;

   tps_counter #(.W(TW)) i_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (tmr_we_i),
      .wdata_i(tmr_wdata_i),
      .tick_i (tmr_tick),
      .value_o(tmr_value_o),
      .ovf_o  (tmr_ovf_o)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) wdt_tick_o <= 1'b0;
      else        wdt_tick_o <= opt.to_wdt ? pre_tick : wdt_raw_i;

   // R4
   direct_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      opt_i[3] && !tmr_we_i && src_tick |=> tmr_value_o == TW'($past(tmr_value_o) + 1'b1));
   // R6
   wdt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !opt_i[3] && wdt_raw_i |=> wdt_tick_o);
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !opt_i[5] && !cyc_en_i && !tmr_we_i |=> $stable(tmr_value_o));
   // R6
   wdt_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      opt_i[3] && !wdt_raw_i |=> !wdt_tick_o);

endmodule

// File: tb/test_tps_timer_top.sv
module test_tps_timer_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_en = 1'b0, pin = 1'b0, twe = 1'b0, wraw = 1'b0, wclr = 1'b0;
   logic [7:0] opt = 8'hFF, twd = 8'h00;
   logic [7:0] tval;
   logic       tovf, wtick;

   int errors = 0, checks = 0, cycles = 0;
   bit chk_on = 1'b0;
   string tag = "R9";

   // knobs, percent
   int p_cyc = 0, p_tog = 0, p_we = 0, p_raw = 0, p_clr = 0;

   always #2 clk = ~clk;

   tps_timer_top i_tps_timer_top (
      .clk(clk), .rst_n(rst_n), .cyc_en_i(cyc_en), .ext_pin_i(pin), .opt_i(opt),
      .tmr_we_i(twe), .tmr_wdata_i(twd), .wdt_raw_i(wraw), .wdt_clr_i(wclr),
      .tmr_value_o(tval), .tmr_ovf_o(tovf), .wdt_tick_o(wtick)
   );

   // Reference model built from the requirements
   logic [7:0] m_tv, m_pc;
   logic       m_ovf, m_wt, m_s1, m_s2, m_s3;

   function automatic logic [7:0] ratio_mask(input logic own_wdt, input logic [2:0] r);
      int sh = own_wdt ? int'(r) : int'(r) + 1;   // R5 / R6 ratios
      return 8'((1 << sh) - 1);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tv = 0; m_pc = 0; m_ovf = 0; m_wt = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      end else begin
         logic own_wdt, edg, src, pin_in, pout, clr, tt;
         logic [7:0] mk;
         own_wdt = opt[3];
         edg  = opt[4] ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
         src  = opt[5] ? edg : cyc_en;
         pin_in = own_wdt ? wraw : src;
         mk   = ratio_mask(own_wdt, opt[2:0]);
         pout = pin_in && ((m_pc & mk) == mk);
         clr  = own_wdt ? wclr : twe;
         tt   = own_wdt ? src : pout;
         m_ovf = !twe && tt && (m_tv == 8'hFF);
         m_tv  = twe ? twd : (tt ? m_tv + 8'd1 : m_tv);
         m_pc  = clr ? 8'd0 : (pin_in ? m_pc + 8'd1 : m_pc);
         m_wt  = own_wdt ? pout : wraw;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
      end
   end

   task automatic check1(input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   always @(negedge clk) if (chk_on) begin
      check1("tmr_value", tval, m_tv);
      check1("tmr_ovf", tovf, m_ovf);
      check1("wdt_tick", wtick, m_wt);
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cyc_en = ($urandom % 100) < p_cyc;
         if (($urandom % 100) < p_tog) pin = ~pin;
         twe  = ($urandom % 100) < p_we;
         twd  = 8'($urandom);
         wraw = ($urandom % 100) < p_raw;
         wclr = ($urandom % 100) < p_clr;
      end
      @(negedge clk);
      cyc_en = 0; twe = 0; wraw = 0; wclr = 0;
   endtask

   task automatic write_tmr(input logic [7:0] v);
      @(negedge clk); twe = 1; twd = v;
      @(negedge clk); twe = 0;
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      tag = "R9";
      check1("reset tmr_value", tval, 0);
      check1("reset tmr_ovf", tovf, 0);
      check1("reset wdt_tick", wtick, 0);
      rst_n = 1;
      chk_on = 1;

      // R1 / R2 / R4: internal source, timer at 1:1, wrap through FFh
      tag = "R1"; opt = 8'h08; write_tmr(8'hF0);
      p_cyc = 100; run(40);
      tag = "R2"; p_cyc = 40; run(300);
      tag = "R4"; p_cyc = 70; p_we = 3; run(300); p_we = 0;

      // R5: every timer-side ratio
      tag = "R5";
      for (int r = 0; r < 8; r++) begin
         opt = 8'(r); p_cyc = 80;
         run((2 << r) * 4 + 20);
      end
      opt = 8'h00; p_cyc = 100; write_tmr(8'hFE); run(12);  // 1:2 across wrap

      // R3: external pin, both edges
      tag = "R3"; p_cyc = 50;
      opt = 8'h28; p_tog = 30; run(400);
      opt = 8'h38; run(400);
      opt = 8'h20; p_tog = 60; run(300);
      p_tog = 0;

      // R6: watchdog ratios and passthrough
      tag = "R6"; p_cyc = 30;
      for (int r = 0; r < 8; r++) begin
         opt = 8'(8'h08 | r); p_raw = 70;
         run((1 << r) * 4 + 20);
      end
      opt = 8'h03; p_raw = 50; run(200);

      // R7: writes racing ticks, prescaler on timer
      tag = "R7"; opt = 8'h01; p_cyc = 100; p_raw = 0;
      @(negedge clk); cyc_en = 1; twe = 1; twd = 8'hFF;
      @(negedge clk); twe = 0;
      run(10);
      p_cyc = 90; p_we = 8; run(500); p_we = 0;

      // R8: clear strobes on both owners
      tag = "R8"; opt = 8'h0A; p_raw = 80; p_clr = 10; p_cyc = 50; run(400);
      opt = 8'h02; p_raw = 50; run(400); p_clr = 0;

      // R10: option FFh and unused bits
      tag = "R10"; opt = 8'hFF; p_raw = 90; p_tog = 40; run(600);
      opt = 8'hC8; p_cyc = 60; run(200);
      opt = 8'h48; run(200);

      // Random mix
      tag = "R1";
      for (int k = 0; k < 20; k++) begin
         opt = 8'($urandom);
         p_cyc = 60; p_tog = 25; p_we = 2; p_raw = 50; p_clr = 4;
         run(200);
      end

      @(negedge clk);
      chk_on = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule